// File: doc/BRIEF.md
# Shared-Bus Serial DAC Write Controller

This block sits on the host side of a group of serial DACs. All of them share one serial clock line and one data line, and each has its own active-low chip-select. A write request comes in over a valid/ready handshake and carries three things: a device index, a 3-bit control code and a 12-bit data value.

The controller builds a 16-bit frame from the request. It drives the chosen chip-select low and waits a programmable setup interval. It then shifts the frame out with 16 serial clock pulses and raises the chip-select, which commits the write in the DAC. It keeps every chip-select high for a minimum interval before it accepts the next request.

The serial clock rate, the setup delay and the inter-frame high time are parameters counted in system clock cycles. A request whose device index does not exist is consumed without any bus activity.

Top module: `dac_bus_writer`

## Requirements
- R1: The frame holds 16 bits, sent first bit first. Bits 1 to 3 are the control code, starting at its bit 2. Bits 4 to 15 are the data value, starting at its bit 11. Bit 16 is always 0.
- R2: At most one chip-select output is low at any time. The low one is `cs_no[idx]`, where idx is the device index of the accepted request.
- R3: `sclk_o` stays low whenever every chip-select is high. The selected chip-select is low for at least `CS_SETUP` system cycles before the first rising edge of `sclk_o`.
- R4: `sdo_o` changes only while `sclk_o` is low. It stays stable for the whole high phase of `sclk_o`, because the DAC samples it on the rising edge.
- R5: Each high phase of `sclk_o` lasts exactly `HALF_DIV` system cycles. Each frame has exactly 16 rising edges of `sclk_o`.
- R6: The chip-select returns high only after the 16th rising edge of `sclk_o`, and only once `sclk_o` is low again.
- R7: Between two frames, every chip-select stays high for at least `CS_GAP` system cycles. `req_ready_o` is low from the cycle after acceptance until the write ends.
- R8: `done_o` pulses for exactly one cycle at the end of each write. `req_ready_o` is high in that same cycle.
- R9: A request with a device index of `N_DEV` or above is accepted and dropped. It lowers no chip-select, produces no `sclk_o` edge and raises no `done_o`.
- R10: While reset is asserted, every chip-select is high, `sclk_o`, `sdo_o` and `done_o` are low, and `req_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Write request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_dev_i | input | DEV_W | Target device index |
| req_ctrl_i | input | 3 | Control code |
| req_data_i | input | 12 | Data value |
| sclk_o | output | 1 | Shared serial clock, idles low |
| sdo_o | output | 1 | Shared serial data |
| cs_no | output | N_DEV | Active-low chip-selects, one per device |
| done_o | output | 1 | One-cycle pulse when a write completes |

## Verification
The bench builds the controller with `N_DEV=3`, so index 3 of the 2-bit index field is a real out-of-range case and the drop path can be exercised. It sets `HALF_DIV=2`, `CS_SETUP=3` and `CS_GAP=4`. These values keep each frame short, so back-to-back writes, the setup window before the first clock edge and the minimum high time between frames can all be measured over many frames. They also leave the setup and gap timers distinct from the clock divider.

// File: rtl/dac_wr_pkg.sv
package dac_wr_pkg;
  localparam int CTRL_W  = 3;
  localparam int DATA_W  = 12;
  localparam int FRAME_W = CTRL_W + DATA_W + 1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT,
    ST_GAP
  } wr_state_e;

  // control first, data MSB first, trailing zero sub-bit
  function automatic logic [FRAME_W-1:0] build_frame(input logic [CTRL_W-1:0] ctrl,
                                                     input logic [DATA_W-1:0] data);
    return {ctrl, data, 1'b0};
  endfunction
endpackage

// File: rtl/dac_wr_tick.sv
module dac_wr_tick #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic [CW-1:0] limit_i,
  output logic          hit_o
);
  logic [CW-1:0] cnt_q;

  assign hit_o = en_i && (cnt_q == limit_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i || hit_o)  cnt_q <= '0;
    else if (en_i)            cnt_q <= cnt_q + 1'b1;
  end

  // timer never runs past its limit (bounds every phase length, R5)
  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i) |-> (cnt_q < limit_i));
endmodule

// File: rtl/dac_wr_shreg.sv
module dac_wr_shreg #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic [W-1:0] frame_i,
  output logic         msb_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= frame_i;
    else if (shift_i) sr_q <= {sr_q[W-2:0], 1'b0};
  end

  assign msb_o = sr_q[W-1];

  p_no_load_shift_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && shift_i));
endmodule

// File: rtl/dac_wr_cs_dec.sv
module dac_wr_cs_dec #(
  parameter int N_DEV = 4,
  parameter int DEV_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DEV_W-1:0] sel_i,
  output logic [N_DEV-1:0] cs_no
);
  for (genvar i = 0; i < N_DEV; i++) begin : g_cs
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cs_no[i] <= 1'b1;
      else         cs_no[i] <= !(en_i && (sel_i == DEV_W'(i)));
    end
  end

  p_one_cs_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~cs_no) <= 1);
endmodule

// File: rtl/dac_bus_writer.sv
module dac_bus_writer
  import dac_wr_pkg::*;
#(
  parameter int N_DEV    = 4,
  parameter int DEV_W    = (N_DEV > 1) ? $clog2(N_DEV) : 1,
  parameter int HALF_DIV = 5,
  parameter int CS_SETUP = 2,
  parameter int CS_GAP   = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [DEV_W-1:0]    req_dev_i,
  input  logic [CTRL_W-1:0]   req_ctrl_i,
  input  logic [DATA_W-1:0]   req_data_i,
  output logic                sclk_o,
  output logic                sdo_o,
  output logic [N_DEV-1:0]    cs_no,
  output logic                done_o
);
  localparam int TMAX1 = (HALF_DIV > CS_SETUP) ? HALF_DIV : CS_SETUP;
  localparam int TMAX  = (TMAX1 > CS_GAP) ? TMAX1 : CS_GAP;
  localparam int CW    = $clog2(TMAX + 1) + 1;
  localparam int BIT_W = $clog2(FRAME_W);
  localparam logic [DEV_W:0]   NDEV_V   = (DEV_W + 1)'(N_DEV);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

  wr_state_e        state_q, state_n;
  logic [DEV_W-1:0] sel_q;
  logic [BIT_W-1:0] bit_q;
  logic             sclk_q, done_q;
  logic             accept, in_range, load, shift, hit, msb, cs_en;
  logic [CW-1:0]    limit;

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign in_range    = {1'b0, req_dev_i} < NDEV_V;

  always_comb begin
    unique case (state_q)
      ST_SETUP: limit = CW'(CS_SETUP);
      ST_SHIFT: limit = CW'(HALF_DIV);
      ST_GAP:   limit = CW'(CS_GAP);
      default:  limit = CW'(1);
    endcase
  end

  always_comb begin
    state_n = state_q;
    load    = 1'b0;
    shift   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept && in_range) begin
        state_n = ST_SETUP;
        load    = 1'b1;
      end
      ST_SETUP: if (hit) state_n = ST_SHIFT;
      ST_SHIFT: if (hit && sclk_q) begin
        if (bit_q == LAST_BIT) state_n = ST_GAP;
        else                   shift   = 1'b1;  // falling edge moves data
      end
      ST_GAP: if (hit) state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  assign cs_en = (state_n == ST_SETUP) || (state_n == ST_SHIFT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sel_q   <= '0;
      bit_q   <= '0;
      sclk_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      if (load) begin
        sel_q <= req_dev_i;
        bit_q <= '0;
      end else if (shift) begin
        bit_q <= bit_q + 1'b1;
      end
      if (state_q != ST_SHIFT) sclk_q <= 1'b0;
      else if (hit)            sclk_q <= ~sclk_q;
      done_q <= (state_q == ST_GAP) && hit;
    end
  end

  dac_wr_tick #(.CW(CW)) u_tick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (state_q == ST_IDLE),
    .en_i    (state_q != ST_IDLE),
    .limit_i (limit),
    .hit_o   (hit)
  );

  dac_wr_shreg #(.W(FRAME_W)) u_shreg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .shift_i (shift),
    .frame_i (build_frame(req_ctrl_i, req_data_i)),
    .msb_o   (msb)
  );

  dac_wr_cs_dec #(.N_DEV(N_DEV), .DEV_W(DEV_W)) u_cs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cs_en),
    .sel_i  (load ? req_dev_i : sel_q),
    .cs_no  (cs_no)
  );

  assign sclk_o = sclk_q;
  assign sdo_o  = ((state_q == ST_SETUP) || (state_q == ST_SHIFT)) && msb;
  assign done_o = done_q;

  p_sclk_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cs_no) |-> !sclk_o);
  p_sdo_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(sdo_o));
  p_cs_rise_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(&cs_no) |-> !sclk_o);
  p_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&cs_no) |-> !req_ready_o);
  p_done_ready_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (req_ready_o && (&cs_no)));
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_reject_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !in_range) |=> ((&cs_no) && req_ready_o));
endmodule

// File: tb/dac_bus_writer_tb_top.sv
module dac_bus_writer_tb_top;
  localparam int N_DEV    = 3;
  localparam int DEV_W    = 2;
  localparam int HALF_DIV = 2;
  localparam int CS_SETUP = 3;
  localparam int CS_GAP   = 4;
  localparam int NVEC     = 6;

  // {dev[1:0], ctrl[2:0], data[11:0]}
  localparam logic [16:0] VEC [NVEC] = '{
    {2'd0, 3'b101, 12'hA5C},
    {2'd1, 3'b011, 12'h001},
    {2'd2, 3'b111, 12'hFFF},
    {2'd0, 3'b000, 12'h000},
    {2'd2, 3'b100, 12'h800},
    {2'd1, 3'b010, 12'h7FF}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0;
  logic req_ready_o;
  logic [DEV_W-1:0] req_dev_i = '0;
  logic [2:0] req_ctrl_i = '0;
  logic [11:0] req_data_i = '0;
  logic sclk_o, sdo_o, done_o;
  logic [N_DEV-1:0] cs_no;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #5 clk_i = ~clk_i;

  dac_bus_writer #(
    .N_DEV(N_DEV), .DEV_W(DEV_W), .HALF_DIV(HALF_DIV),
    .CS_SETUP(CS_SETUP), .CS_GAP(CS_GAP)
  ) dut_i (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_dev_i,
    .req_ctrl_i, .req_data_i, .sclk_o, .sdo_o, .cs_no, .done_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus monitor, sampled on the falling system clock edge
  logic prev_sclk = 1'b0, prev_sdo = 1'b0, prev_all_hi = 1'b1, prev_done = 1'b0;
  logic [15:0] cap = '0, last_frame = '0;
  int nrise = 0, last_nrise = 0, low_cnt = 0, setup_seen = 0;
  int sel_seen = -1, last_sel = -1;
  int hi_run = 0, gap_min = 1000, had_frame = 0;
  int hi_len = 0, r4_bad = 0, r5_bad = 0, r6_bad = 0, r8_bad = 0, stray = 0;
  int cs_falls = 0, n_done = 0, multi_cs = 0;

  always @(negedge clk_i) begin
    if (rst_ni) begin
      logic all_hi;
      all_hi = &cs_no;
      if ($countones(~cs_no) > 1) multi_cs++;
      if (!all_hi && prev_all_hi) begin
        cs_falls++;
        cap = '0; nrise = 0; low_cnt = 0;
        for (int i = 0; i < N_DEV; i++) if (!cs_no[i]) sel_seen = i;
        if (had_frame != 0 && hi_run < gap_min) gap_min = hi_run;
      end
      if (!all_hi) begin
        if (sclk_o && !prev_sclk) begin
          if (nrise == 0) setup_seen = low_cnt;
          cap = {cap[14:0], sdo_o};
          nrise++;
        end
        low_cnt++;
      end else begin
        if (sclk_o && !prev_sclk) stray++;
        if (!prev_all_hi) begin
          if (sclk_o) r6_bad++;
          last_frame = cap; last_nrise = nrise; last_sel = sel_seen;
          had_frame = 1; hi_run = 0;
        end
        hi_run++;
      end
      if (sclk_o && prev_sclk && sdo_o != prev_sdo) r4_bad++;
      if (sclk_o) hi_len++;
      else begin
        if (prev_sclk && hi_len != HALF_DIV) r5_bad++;
        hi_len = 0;
      end
      if (done_o) begin
        n_done++;
        if (prev_done) r8_bad++;
      end
      prev_sclk = sclk_o; prev_sdo = sdo_o; prev_all_hi = all_hi; prev_done = done_o;
    end
  end

  // caller stands at a falling clock edge
  task automatic send(input logic [1:0] dev, input logic [2:0] ctrl, input logic [11:0] data);
    req_valid_i = 1'b1; req_dev_i = dev; req_ctrl_i = ctrl; req_data_i = data;
    while (!req_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic wait_done(output bit got, output bit rdy);
    got = 0; rdy = 0;
    for (int k = 0; k < 2000 && !got; k++) begin
      @(negedge clk_i); #1;
      if (done_o) begin got = 1; rdy = req_ready_o; end
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit got, rdy;
    int falls0, done0;
    // R10 reset state
    repeat (3) @(negedge clk_i);
    chk(cs_no == '1, "R10 cs", int'(cs_no), 7);
    chk(sclk_o == 1'b0, "R10 sclk", int'(sclk_o), 0);
    chk(sdo_o == 1'b0, "R10 sdo", int'(sdo_o), 0);
    chk(done_o == 1'b0, "R10 done", int'(done_o), 0);
    chk(req_ready_o == 1'b1, "R10 ready", int'(req_ready_o), 1);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int v = 0; v < NVEC; v++) begin
      logic [15:0] exp_frame;
      exp_frame = {VEC[v][14:12], VEC[v][11:0], 1'b0};
      send(VEC[v][16:15], VEC[v][14:12], VEC[v][11:0]);
      chk(req_ready_o == 1'b0, "R7 ready low after accept", int'(req_ready_o), 0);
      wait_done(got, rdy);
      chk(got, "R8 done seen", int'(got), 1);
      chk(rdy, "R8 ready with done", int'(rdy), 1);
      chk(last_frame == exp_frame, "R1 frame", int'(last_frame), int'(exp_frame));
      chk(last_nrise == 16, "R5 rising edges", last_nrise, 16);
      chk(last_sel == int'(VEC[v][16:15]), "R2 selected cs", last_sel, int'(VEC[v][16:15]));
      chk(setup_seen >= CS_SETUP, "R3 setup", setup_seen, CS_SETUP);
    end

    // R9 out-of-range index
    falls0 = cs_falls; done0 = n_done;
    send(2'd3, 3'b111, 12'hABC);
    chk(req_ready_o == 1'b1, "R9 ready after drop", int'(req_ready_o), 1);
    repeat (60) @(negedge clk_i);
    chk(cs_falls == falls0, "R9 no cs", cs_falls - falls0, 0);
    chk(n_done == done0, "R9 no done", n_done - done0, 0);

    // a valid write right after a dropped one still works
    send(2'd2, 3'b001, 12'h3C3);
    wait_done(got, rdy);
    chk(got && last_frame == 16'h3C3 << 1 | 16'h2000, "R1 frame after drop",
        int'(last_frame), int'(16'h2786));

    chk(gap_min >= CS_GAP, "R7 cs high gap", gap_min, CS_GAP);
    chk(r4_bad == 0, "R4 sdo stable while sclk high", r4_bad, 0);
    chk(r5_bad == 0, "R5 high phase length", r5_bad, 0);
    chk(r6_bad == 0, "R6 cs rise with sclk low", r6_bad, 0);
    chk(stray == 0, "R3 no sclk with cs high", stray, 0);
    chk(r8_bad == 0, "R8 single-cycle done", r8_bad, 0);
    chk(multi_cs == 0, "R2 one cs at a time", multi_cs, 0);
    chk(n_done == NVEC + 1, "R8 done count", n_done, NVEC + 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule